// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Latch

This block is the digital control core of a full H-bridge motor driver. Two polarity inputs pick, for each half-bridge, whether the high-side or the low-side switch conducts. Two disable inputs of opposite sense and an enable input can force every switch off. The block drives four gate-enable outputs, one for the high side and one for the low side of each half-bridge. It also drives an active-low fault flag and a sleep indication.

Undervoltage, overtemperature and short-circuit event inputs come from analog comparators. A tri-state request comes from the current limiter. An undervoltage recovers by itself. A short circuit or overtemperature latches the bridge off until software produces a clearing edge on a disable input, or until the block is reset (supply cycle). An overtemperature latch also needs the cool-down indication at the moment of clearing.

All control and event inputs pass through a two-flop synchronizer. Each half-bridge has a dead-time sequencer, so its two switches are never on together and a direction change always leaves a programmed gap with both switches off.

Top module: `hbridge_ctrl`

## Requirements
- R1: After reset, with the inputs at their idle levels (enable 0, high-active disable 1, low-active disable 0), all four gate outputs are 0, `fault_n_o` is 1 and `sleep_o` is 1.
- R2: When enabled, not disabled and fault-free, half A drives its high gate (`gate_hi_o[0]`) when `pol_a_i` is 1 and its low gate (`gate_lo_o[0]`) when it is 0. Half B uses bit 1 and `pol_b_i` in the same way.
- R3: Equal polarity inputs brake the motor. Both 1 turns on both high gates, and both 0 turns on both low gates.
- R4: `dis_hi_i` = 1 or `dis_lo_n_i` = 0 turns all gates off and leaves `fault_n_o` at 1.
- R5: `enable_i` = 0 turns all gates off and sets `sleep_o` to 1. `enable_i` = 1 clears `sleep_o`.
- R6: While `uv_i` is 1, all gates are off and `fault_n_o` is 0. When it returns to 0, the gates follow the inputs again and `fault_n_o` returns to 1 without any clearing action.
- R7: A pulse on `sc_i` or `ot_i` latches all gates off and `fault_n_o` at 0. The latch holds after the event ends, and polarity changes do not affect it.
- R8: A latched fault clears only on a 1-to-0 edge of `dis_hi_i`, a 0-to-1 edge of `dis_lo_n_i`, or reset. A short circuit that is still present at the clearing edge keeps the latch set.
- R9: An overtemperature latch is released by a clearing edge only while `ot_cool_i` is 1. Otherwise it stays set.
- R10: `ilim_off_i` = 1 turns all gates off without pulling `fault_n_o` low.
- R11: The high and low gates of one half are never 1 together. When a half changes side, both of its gates are 0 for exactly DEAD_CYC+1 cycles.
- R12: An input change reaches the gate outputs at the third rising clock edge after it is applied (two synchronizer flops plus the gate register). Turn-off takes no extra dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (supply cycle) |
| pol_a_i | input | 1 | Polarity of half-bridge A (1 = high side) |
| pol_b_i | input | 1 | Polarity of half-bridge B (1 = high side) |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_n_i | input | 1 | Disable, active low |
| enable_i | input | 1 | 1 = operate, 0 = sleep |
| uv_i | input | 1 | Supply undervoltage event |
| ot_i | input | 1 | Overtemperature event |
| ot_cool_i | input | 1 | Temperature below threshold minus hysteresis |
| sc_i | input | 1 | Short-circuit event |
| ilim_off_i | input | 1 | Tri-state request from the current limiter |
| gate_hi_o | output | 2 | High-side gate enables, bit 0 = half A |
| gate_lo_o | output | 2 | Low-side gate enables, bit 0 = half A |
| fault_n_o | output | 1 | Fault flag, active low |
| sleep_o | output | 1 | Sleep indication |

## Verification
The bench builds the block with DEAD_CYC = 4 and the default two synchronizer stages. This keeps a direction reversal short enough to count its off gap cycle by cycle (five cycles expected). The three-edge input latency can then be checked exactly, without the dead time hiding it. With these values every fault, clear and recovery sequence settles within a dozen cycles, so the bench can walk the latch through set, held-while-present, refused-while-hot and cleared paths in one short run.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    // Driven state of one half-bridge
    typedef enum logic [1:0] {
        HB_OFF  = 2'd0,
        HB_HIGH = 2'd1,
        HB_LOW  = 2'd2
    } hb_state_e;

    // Bundle of asynchronous control and event inputs
    typedef struct packed {
        logic pol_a;
        logic pol_b;
        logic dis_hi;
        logic dis_lo_n;
        logic en;
        logic uv;
        logic ot;
        logic ot_cool;
        logic sc;
        logic ilim;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);

    // Safe levels held by the synchronizer during reset
    localparam ctl_in_t CTL_IDLE = '{
        pol_a:    1'b0,
        pol_b:    1'b0,
        dis_hi:   1'b1,
        dis_lo_n: 1'b0,
        en:       1'b0,
        uv:       1'b0,
        ot:       1'b0,
        ot_cool:  1'b0,
        sc:       1'b0,
        ilim:     1'b0
    };

    // Requested state of a half-bridge
    function automatic hb_state_e hb_target(input logic off, input logic pol);
        if (off)
            return HB_OFF;
        else if (pol)
            return HB_HIGH;
        else
            return HB_LOW;
    endfunction

endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stg[0] <= RST_VAL;
        else
            stg[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= RST_VAL;
            else
                stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hbc_fault.sv
module hbc_fault (
    input  logic clk,
    input  logic rst,
    input  logic dis_hi_s,
    input  logic dis_lo_n_s,
    input  logic ot_s,
    input  logic ot_cool_s,
    input  logic sc_s,
    output logic sc_latch_o,
    output logic ot_latch_o,
    output logic clear_evt_o
);

    logic dis_hi_q;
    logic dis_lo_n_q;

    // Previous synchronized disable levels for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            dis_hi_q   <= 1'b1;
            dis_lo_n_q <= 1'b0;
        end else begin
            dis_hi_q   <= dis_hi_s;
            dis_lo_n_q <= dis_lo_n_s;
        end
    end

    // Clearing edge: high-active disable released or low-active disable released
    assign clear_evt_o = (dis_hi_q & ~dis_hi_s) | (~dis_lo_n_q & dis_lo_n_s);

    // Short-circuit latch: set dominates clear
    always_ff @(posedge clk) begin
        if (rst)
            sc_latch_o <= 1'b0;
        else if (sc_s)
            sc_latch_o <= 1'b1;
        else if (clear_evt_o)
            sc_latch_o <= 1'b0;
    end

    // Overtemperature latch: clear also needs the cool-down indication
    always_ff @(posedge clk) begin
        if (rst)
            ot_latch_o <= 1'b0;
        else if (ot_s)
            ot_latch_o <= 1'b1;
        else if (clear_evt_o && ot_cool_s)
            ot_latch_o <= 1'b0;
    end

endmodule

// File: rtl/hbc_deadtime.sv
module hbc_deadtime
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  hb_state_e tgt_i,
    output logic      hi_o,
    output logic      lo_o
);

    localparam int            CW      = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC);

    hb_state_e     cur;
    logic [CW-1:0] cnt;

    // Turn-off is immediate; turn-on waits for the dead-time counter
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= HB_OFF;
            cnt <= '0;
        end else if (tgt_i != cur) begin
            if (cur != HB_OFF) begin
                cur <= HB_OFF;
                cnt <= DEAD_LD;
            end else if (cnt == '0) begin
                cur <= tgt_i;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign hi_o = (cur == HB_HIGH);
    assign lo_o = (cur == HB_LOW);

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbc_pkg::*;
#(
    parameter int DEAD_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pol_a_i,
    input  logic       pol_b_i,
    input  logic       dis_hi_i,
    input  logic       dis_lo_n_i,
    input  logic       enable_i,
    input  logic       uv_i,
    input  logic       ot_i,
    input  logic       ot_cool_i,
    input  logic       sc_i,
    input  logic       ilim_off_i,
    output logic [1:0] gate_hi_o,
    output logic [1:0] gate_lo_o,
    output logic       fault_n_o,
    output logic       sleep_o
);

    localparam int NHALF = 2;

    ctl_in_t           raw;
    ctl_in_t           syn;
    logic              sc_latch;
    logic              ot_latch;
    logic              clear_evt;
    logic              bridge_off;
    logic [NHALF-1:0]  pol;

    assign raw = '{
        pol_a:    pol_a_i,
        pol_b:    pol_b_i,
        dis_hi:   dis_hi_i,
        dis_lo_n: dis_lo_n_i,
        en:       enable_i,
        uv:       uv_i,
        ot:       ot_i,
        ot_cool:  ot_cool_i,
        sc:       sc_i,
        ilim:     ilim_off_i
    };

    hbc_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (syn)
    );

    hbc_fault u_fault (
        .clk         (clk),
        .rst         (rst),
        .dis_hi_s    (syn.dis_hi),
        .dis_lo_n_s  (syn.dis_lo_n),
        .ot_s        (syn.ot),
        .ot_cool_s   (syn.ot_cool),
        .sc_s        (syn.sc),
        .sc_latch_o  (sc_latch),
        .ot_latch_o  (ot_latch),
        .clear_evt_o (clear_evt)
    );

    assign bridge_off = ~syn.en | syn.dis_hi | ~syn.dis_lo_n | syn.uv
                      | sc_latch | ot_latch | syn.ilim;

    assign pol = {syn.pol_b, syn.pol_a};

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        hb_state_e tgt;
        assign tgt = hb_target(bridge_off, pol[g]);

        hbc_deadtime #(
            .DEAD_CYC (DEAD_CYC)
        ) u_dt (
            .clk   (clk),
            .rst   (rst),
            .tgt_i (tgt),
            .hi_o  (gate_hi_o[g]),
            .lo_o  (gate_lo_o[g])
        );
    end

    assign fault_n_o = ~(syn.uv | sc_latch | ot_latch);
    assign sleep_o   = ~syn.en;

endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
    parameter int DEAD_CYC = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] gate_hi,
    input logic [1:0] gate_lo,
    input logic       fault_n,
    input logic       en_s,
    input logic       dis_hi_s,
    input logic       dis_lo_n_s,
    input logic       uv_s,
    input logic       sc_s,
    input logic       ilim_s,
    input logic       clear_evt
);

    localparam int            SAT = DEAD_CYC + 1;
    localparam int            OW  = $clog2(SAT + 1) + 1;
    localparam logic [OW-1:0] SAT_V = OW'(SAT);

    assert_disable_off_R4: assert property (@(posedge clk) disable iff (rst)
        (dis_hi_s || !dis_lo_n_s) |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

    assert_sleep_off_R5: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

    assert_uv_flag_R6: assert property (@(posedge clk) disable iff (rst)
        uv_s |-> !fault_n);

    assert_sc_flag_R7: assert property (@(posedge clk) disable iff (rst)
        sc_s |=> !fault_n);

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!fault_n && !uv_s && !clear_evt) |=> !fault_n);

    assert_ilim_off_R10: assert property (@(posedge clk) disable iff (rst)
        ilim_s |=> (gate_hi == 2'b00 && gate_lo == 2'b00));

    for (genvar g = 0; g < 2; g++) begin : g_gap
        logic [OW-1:0] off_run;
        logic          was_hi;
        logic          was_lo;

        always_ff @(posedge clk) begin
            if (rst) begin
                off_run <= SAT_V;
                was_hi  <= 1'b0;
                was_lo  <= 1'b0;
            end else begin
                if (!gate_hi[g] && !gate_lo[g])
                    off_run <= (off_run >= SAT_V) ? SAT_V : off_run + 1'b1;
                else
                    off_run <= '0;
                if (gate_hi[g]) begin
                    was_hi <= 1'b1;
                    was_lo <= 1'b0;
                end else if (gate_lo[g]) begin
                    was_hi <= 1'b0;
                    was_lo <= 1'b1;
                end
            end
        end

        assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
            !(gate_hi[g] && gate_lo[g]));

        assert_gap_to_low_R11: assert property (@(posedge clk) disable iff (rst)
            ($rose(gate_lo[g]) && was_hi) |-> (off_run >= SAT_V));

        assert_gap_to_high_R11: assert property (@(posedge clk) disable iff (rst)
            ($rose(gate_hi[g]) && was_lo) |-> (off_run >= SAT_V));
    end

endmodule

bind hbridge_ctrl hbc_checker #(
    .DEAD_CYC (DEAD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gate_hi    (gate_hi_o),
    .gate_lo    (gate_lo_o),
    .fault_n    (fault_n_o),
    .en_s       (syn.en),
    .dis_hi_s   (syn.dis_hi),
    .dis_lo_n_s (syn.dis_lo_n),
    .uv_s       (syn.uv),
    .sc_s       (syn.sc),
    .ilim_s     (syn.ilim),
    .clear_evt  (clear_evt)
);

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;

    localparam int DEAD = 4;
    localparam int SETTLE = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pol_a = 1'b0, pol_b = 1'b0;
    logic       dis_hi = 1'b1, dis_lo_n = 1'b0, enable = 1'b0;
    logic       uv = 1'b0, ot = 1'b0, ot_cool = 1'b0, sc = 1'b0, ilim = 1'b0;
    logic [1:0] gate_hi, gate_lo;
    logic       fault_n, sleep;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] hi;
        logic [1:0] lo;
        logic       fn;
        logic       sl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    hbridge_ctrl #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .pol_a_i    (pol_a),
        .pol_b_i    (pol_b),
        .dis_hi_i   (dis_hi),
        .dis_lo_n_i (dis_lo_n),
        .enable_i   (enable),
        .uv_i       (uv),
        .ot_i       (ot),
        .ot_cool_i  (ot_cool),
        .sc_i       (sc),
        .ilim_off_i (ilim),
        .gate_hi_o  (gate_hi),
        .gate_lo_o  (gate_lo),
        .fault_n_o  (fault_n),
        .sleep_o    (sleep)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (gate_hi !== e.hi || gate_lo !== e.lo || fault_n !== e.fn || sleep !== e.sl) begin
                    miscompares++;
                    $display("FAIL %s: actual hi=%b lo=%b fault_n=%b sleep=%b expected hi=%b lo=%b fault_n=%b sleep=%b",
                             e.tag, gate_hi, gate_lo, fault_n, sleep, e.hi, e.lo, e.fn, e.sl);
                end
            end
        end
    end

    // Driver side: wait for settling, then push the expected state
    task automatic expect_state(input string tag, input logic [1:0] hi, input logic [1:0] lo,
                                input logic fn, input logic sl);
        exp_t e;
        repeat (SETTLE) @(negedge clk);
        e.hi = hi; e.lo = lo; e.fn = fn; e.sl = sl; e.tag = tag;
        exp_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic direct_check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_dis_hi();
        @(negedge clk) dis_hi = 1'b1;
        repeat (6) @(negedge clk);
        dis_hi = 1'b0;
    endtask

    task automatic pulse_dis_lo_n();
        @(negedge clk) dis_lo_n = 1'b0;
        repeat (6) @(negedge clk);
        dis_lo_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: idle inputs after reset
        expect_state("R1 reset", 2'b00, 2'b00, 1'b1, 1'b1);

        // R2: forward (A high side, B low side)
        @(negedge clk);
        enable = 1'b1; dis_hi = 1'b0; dis_lo_n = 1'b1; pol_a = 1'b1; pol_b = 1'b0;
        expect_state("R2 forward", 2'b01, 2'b10, 1'b1, 1'b0);

        // R11: reversal gap on half A, counted at the outputs
        @(negedge clk);
        pol_a = 1'b0; pol_b = 1'b1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (gate_hi[0] == 1'b0 && gate_lo[0] == 1'b0) n++;
            if (gate_lo[0]) break;
        end
        direct_check("R11 dead gap half A", n, DEAD + 1);
        expect_state("R2 reverse", 2'b10, 2'b01, 1'b1, 1'b0);

        // R3: braking both ways
        @(negedge clk) pol_a = 1'b1; pol_b = 1'b1;
        expect_state("R3 brake high", 2'b11, 2'b00, 1'b1, 1'b0);
        @(negedge clk) pol_a = 1'b0; pol_b = 1'b0;
        expect_state("R3 brake low", 2'b00, 2'b11, 1'b1, 1'b0);

        // R4: both disables, flag stays high
        @(negedge clk) pol_a = 1'b1; pol_b = 1'b0;
        expect_state("R2 forward again", 2'b01, 2'b10, 1'b1, 1'b0);
        @(negedge clk) dis_hi = 1'b1;
        expect_state("R4 high-active disable", 2'b00, 2'b00, 1'b1, 1'b0);
        @(negedge clk) dis_hi = 1'b0; dis_lo_n = 1'b0;
        expect_state("R4 low-active disable", 2'b00, 2'b00, 1'b1, 1'b0);
        @(negedge clk) dis_lo_n = 1'b1;

        // R5: sleep
        @(negedge clk) enable = 1'b0;
        expect_state("R5 sleep", 2'b00, 2'b00, 1'b1, 1'b1);
        @(negedge clk) enable = 1'b1;
        expect_state("R5 wake", 2'b01, 2'b10, 1'b1, 1'b0);

        // R6: undervoltage with automatic recovery
        @(negedge clk) uv = 1'b1;
        expect_state("R6 undervoltage", 2'b00, 2'b00, 1'b0, 1'b0);
        @(negedge clk) uv = 1'b0;
        expect_state("R6 recovery", 2'b01, 2'b10, 1'b1, 1'b0);

        // R10: current limiter tri-state request
        @(negedge clk) ilim = 1'b1;
        expect_state("R10 limiter off", 2'b00, 2'b00, 1'b1, 1'b0);
        @(negedge clk) ilim = 1'b0;
        expect_state("R10 limiter release", 2'b01, 2'b10, 1'b1, 1'b0);

        // R7: short-circuit pulse latches; polarity changes ignored
        @(negedge clk) sc = 1'b1;
        repeat (4) @(negedge clk);
        sc = 1'b0;
        expect_state("R7 short latched", 2'b00, 2'b00, 1'b0, 1'b0);
        @(negedge clk) pol_a = 1'b0; pol_b = 1'b1;
        expect_state("R7 polarity ignored", 2'b00, 2'b00, 1'b0, 1'b0);

        // R8: short still present at clearing edge keeps latch
        @(negedge clk) sc = 1'b1;
        pulse_dis_hi();
        expect_state("R8 clear refused while short", 2'b00, 2'b00, 1'b0, 1'b0);
        @(negedge clk) sc = 1'b0;
        expect_state("R8 no clear without edge", 2'b00, 2'b00, 1'b0, 1'b0);
        pulse_dis_lo_n();
        expect_state("R8 cleared by low-active edge", 2'b10, 2'b01, 1'b1, 1'b0);

        // R9: overtemperature clear gated by cool-down
        @(negedge clk) ot = 1'b1; ot_cool = 1'b0;
        repeat (4) @(negedge clk);
        ot = 1'b0;
        expect_state("R9 overtemp latched", 2'b00, 2'b00, 1'b0, 1'b0);
        pulse_dis_hi();
        expect_state("R9 clear refused while hot", 2'b00, 2'b00, 1'b0, 1'b0);
        @(negedge clk) ot_cool = 1'b1;
        pulse_dis_hi();
        expect_state("R9 cleared when cool", 2'b10, 2'b01, 1'b1, 1'b0);

        // R12: turn-off latency of three rising edges, no dead time
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        direct_check("R12 still on after two edges", int'(gate_hi[1]), 1);
        @(negedge clk);
        direct_check("R12 off after third edge", int'(gate_hi[1]), 0);
        direct_check("R12 sleep after two edges", int'(sleep), 1);

        // R1: reset acts as the supply cycle and clears a latch
        @(negedge clk) enable = 1'b1; sc = 1'b1;
        repeat (4) @(negedge clk);
        sc = 1'b0;
        expect_state("R7 short latched before reset", 2'b00, 2'b00, 1'b0, 1'b0);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_state("R8 reset clears latch", 2'b10, 2'b01, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule